// File: doc/BRIEF.md
# Three-Floor Elevator Move Controller

This block decides, one clock tick at a time, how far an elevator car serving three floors must travel. It keeps the floor the car stands at. In every tick it samples three request lines, one for each floor. In that same tick it raises exactly one movement strobe: descend two floors, descend one, stay put, ascend one, or ascend two. The strobe is a Mealy output, and the stored floor takes the requested value at the clock edge that ends the tick. Each move is treated as finished within that tick. Door handling, motor timing and travel time belong to the logic around the block.

The distance comes from the signed difference between the requested floor and the current floor, not from a plain up/down flag. When several requests arrive together, the lowest-numbered floor is served and the other requests are dropped. When no request arrives, the controller stays quiet and the floor holds. A synchronous active-high reset returns the car to floor 1.

Top module: `elev_move_ctrl`

## Requirements
- R1: While `rst` is high, all five command outputs are low. After a clock edge sampled with `rst` high, `atFloor` equals 1, whatever the requests were.
- R2: A request for the floor the car occupies raises `cmdIdle` only, and `atFloor` is unchanged after the edge.
- R3: A request for a higher floor raises `cmdUp1` when the difference is one and `cmdUp2` when it is two. `atFloor` becomes the requested floor after the edge.
- R4: A request for a lower floor raises `cmdDown1` when the difference is one and `cmdDown2` when it is two. `atFloor` becomes the requested floor after the edge.
- R5: The command is combinational in the requests and the stored floor. It is valid in the same cycle the request is presented, before the edge that updates the floor.
- R6: With `reqFloor` all zero, every command output is low and `atFloor` holds.
- R7: With more than one request bit set, only the lowest-numbered requested floor is acted on. The other requests have no effect on the command or on the next floor.
- R8: At most one of the five command outputs is high in any cycle.
- R9: Bit i of `reqFloor` requests floor i+1. `atFloor` is the binary floor number 1, 2 or 3 and never holds any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqFloor | input | 3 | Floor requests, bit 0 = floor 1 |
| cmdDown2 | output | 1 | Move down two floors |
| cmdDown1 | output | 1 | Move down one floor |
| cmdIdle | output | 1 | Stay at the current floor |
| cmdUp1 | output | 1 | Move up one floor |
| cmdUp2 | output | 1 | Move up two floors |
| atFloor | output | 2 | Current floor number (1 to 3) |

## Verification
Two functions can fall in the same cycle. The first is the arbitration among simultaneous requests. The second is the distance calculation against the stored floor, and it has to use the floor that won arbitration. Vectors that combine two or three requests are driven from every floor, so the winner lies sometimes below the car, sometimes above it and sometimes at it. Each such vector is judged twice: the single strobe is checked before the edge, and the floor is checked after the edge. The second pairing is reset arriving together with a request. Here the bench expects every strobe low and floor 1 afterwards.

// File: rtl/elev_pkg.sv
package elev_pkg;
  localparam int FLOORS  = 3;
  localparam int FLOOR_W = $clog2(FLOORS + 1);
  localparam int DIFF_W  = FLOOR_W + 1;

  typedef logic [FLOOR_W-1:0] floor_t;

  // strobes from control to the floor register
  typedef struct packed {
    logic   load;
    floor_t target;
  } floorStrobe_t;

  typedef struct packed {
    logic down2;
    logic down1;
    logic idle;
    logic up1;
    logic up2;
  } moveCmd_t;
endpackage

// File: rtl/elev_floor_reg.sv
module elev_floor_reg
  import elev_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  floorStrobe_t strobe,
  output floor_t       curFloor
);
  localparam floor_t HOME = floor_t'(1);

  always_ff @(posedge clk) begin
    if (rst)              curFloor <= HOME;
    else if (strobe.load) curFloor <= strobe.target;
  end

  assert_floor_range_R9: assert property (@(posedge clk) disable iff (rst)
    (curFloor >= floor_t'(1)) && (curFloor <= floor_t'(FLOORS)));

  assert_hold_without_load_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(curFloor));
endmodule

// File: rtl/elev_ctrl.sv
module elev_ctrl
  import elev_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLOORS-1:0] reqFloor,
  input  floor_t            curFloor,
  output floorStrobe_t      strobe,
  output moveCmd_t          cmd
);
  logic                      hit;
  floor_t                    target;
  logic signed [DIFF_W-1:0]  diff;

  // lowest-numbered request wins: scan downward, last match kept
  always_comb begin
    hit    = 1'b0;
    target = '0;
    for (int i = FLOORS - 1; i >= 0; i--) begin
      if (reqFloor[i]) begin
        hit    = 1'b1;
        target = floor_t'(i + 1);
      end
    end
  end

  assign diff = $signed({1'b0, target}) - $signed({1'b0, curFloor});

  always_comb begin
    cmd = '0;
    if (hit && !rst) begin
      case (diff)
        -DIFF_W'(2): cmd.down2 = 1'b1;
        -DIFF_W'(1): cmd.down1 = 1'b1;
        DIFF_W'(0):  cmd.idle  = 1'b1;
        DIFF_W'(1):  cmd.up1   = 1'b1;
        DIFF_W'(2):  cmd.up2   = 1'b1;
        default:     cmd       = '0;
      endcase
    end
  end

  assign strobe.load   = hit && !rst;
  assign strobe.target = target;

  assert_cmd_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd));

  assert_quiet_no_request_R6: assert property (@(posedge clk) disable iff (rst)
    (reqFloor == '0) |-> (cmd == '0));

  assert_request_gives_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (reqFloor != '0) |-> ($countones(cmd) == 1));
endmodule

// File: rtl/elev_move_ctrl.sv
module elev_move_ctrl
  import elev_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLOORS-1:0] reqFloor,
  output logic              cmdDown2,
  output logic              cmdDown1,
  output logic              cmdIdle,
  output logic              cmdUp1,
  output logic              cmdUp2,
  output logic [FLOOR_W-1:0] atFloor
);
  floorStrobe_t strobe;
  moveCmd_t     cmd;

  elev_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqFloor(reqFloor),
    .curFloor(atFloor), .strobe(strobe), .cmd(cmd)
  );

  elev_floor_reg u_floor (
    .clk(clk), .rst(rst), .strobe(strobe), .curFloor(atFloor)
  );

  assign cmdDown2 = cmd.down2;
  assign cmdDown1 = cmd.down1;
  assign cmdIdle  = cmd.idle;
  assign cmdUp1   = cmd.up1;
  assign cmdUp2   = cmd.up2;

  assert_reset_home_R1: assert property (@(posedge clk)
    rst |=> (atFloor == FLOOR_W'(1)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> !(cmdDown2 || cmdDown1 || cmdIdle || cmdUp1 || cmdUp2));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    cmdIdle |=> $stable(atFloor));

  assert_up1_step_R3: assert property (@(posedge clk) disable iff (rst)
    cmdUp1 |=> (atFloor == $past(atFloor) + FLOOR_W'(1)));

  assert_up2_top_R3: assert property (@(posedge clk) disable iff (rst)
    cmdUp2 |=> (atFloor == FLOOR_W'(FLOORS)));

  assert_down1_step_R4: assert property (@(posedge clk) disable iff (rst)
    cmdDown1 |=> (atFloor == $past(atFloor) - FLOOR_W'(1)));

  assert_down2_bottom_R4: assert property (@(posedge clk) disable iff (rst)
    cmdDown2 |=> (atFloor == FLOOR_W'(1)));
endmodule

// File: tb/elev_move_ctrl_bench.sv
module elev_move_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reqFloor = 3'b000;
  logic       cmdDown2, cmdDown1, cmdIdle, cmdUp1, cmdUp2;
  logic [1:0] atFloor;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  elev_move_ctrl u_elev_move_ctrl (
    .clk(clk), .rst(rst), .reqFloor(reqFloor),
    .cmdDown2(cmdDown2), .cmdDown1(cmdDown1), .cmdIdle(cmdIdle),
    .cmdUp1(cmdUp1), .cmdUp2(cmdUp2), .atFloor(atFloor)
  );

  // {req[2:0], cmd {down2,down1,idle,up1,up2}, floor after edge}
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {3'b001, 5'b00100, 2'd1},
    {3'b010, 5'b00010, 2'd2},
    {3'b100, 5'b00010, 2'd3},
    {3'b001, 5'b10000, 2'd1},
    {3'b100, 5'b00001, 2'd3},
    {3'b010, 5'b01000, 2'd2},
    {3'b000, 5'b00000, 2'd2},
    {3'b100, 5'b00010, 2'd3},
    {3'b100, 5'b00100, 2'd3},
    {3'b110, 5'b01000, 2'd2},
    {3'b111, 5'b01000, 2'd1},
    {3'b110, 5'b00010, 2'd2},
    {3'b011, 5'b01000, 2'd1},
    {3'b010, 5'b00010, 2'd2},
    {3'b010, 5'b00100, 2'd2},
    {3'b001, 5'b01000, 2'd1},
    {3'b101, 5'b00100, 2'd1}
  };

  function automatic logic [4:0] cmdNow();
    return {cmdDown2, cmdDown1, cmdIdle, cmdUp1, cmdUp2};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [2:0] r, input logic [4:0] c);
    if ($countones(r) > 1) return "R7";
    if (c == 5'b00000)     return "R6";
    if (c[2])              return "R2";
    if (c[1] || c[0])      return "R3";
    return "R4";
  endfunction

  // drive after negedge, sample command before posedge (R5: same cycle),
  // sample floor after the posedge
  task automatic step(input logic [2:0] r, input logic [4:0] expCmd,
                      input logic [1:0] expFloor, input string tag);
    @(negedge clk);
    reqFloor = r;
    #1;
    check({tag, " cmd R5"}, int'(cmdNow()), int'(expCmd));
    check("R8 onehot", int'($countones(cmdNow()) <= 1), 1);
    @(posedge clk);
    #1;
    check({tag, " floor R9"}, int'(atFloor), int'(expFloor));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset floor", int'(atFloor), 1);
    check("R1 reset cmd quiet", int'(cmdNow()), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      step(VEC[i][9:7], VEC[i][6:2], VEC[i][1:0], tagFor(VEC[i][9:7], VEC[i][6:2]));

    // R6: idle ticks hold the floor over several cycles
    step(3'b100, 5'b00001, 2'd3, "R3");
    step(3'b000, 5'b00000, 2'd3, "R6");
    step(3'b000, 5'b00000, 2'd3, "R6");

    // R1: reset together with a request from floor 3
    @(negedge clk);
    rst = 1'b1;
    reqFloor = 3'b010;
    #1;
    check("R1 cmd low in reset", int'(cmdNow()), 0);
    @(posedge clk);
    #1;
    check("R1 floor home after reset", int'(atFloor), 1);
    @(negedge clk);
    rst = 1'b0;
    reqFloor = 3'b000;
    #1;
    check("R6 quiet after reset", int'(cmdNow()), 0);

    // R7: all three requests from floor 3 served as floor 1
    step(3'b100, 5'b00001, 2'd3, "R3");
    step(3'b111, 5'b10000, 2'd1, "R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule